// File: doc/BRIEF.md
# Flash Self-Programming Command Arming Unit

This block sits between the CPU and a flash controller and decides when a program-memory store issued by software becomes a real flash operation. Software first writes a five-bit command value into the arming register. Only five exact bit patterns are legal: the enable bit alone, or the enable bit together with exactly one command bit. A legal pattern opens a short window. If a store strobe from the CPU arrives inside that window, the armed command is executed and passed to the flash controller as a command code with a one-cycle start pulse and an address.

Page erase and page write are long operations. While one runs, the arming register keeps showing its pattern, and that pattern clears only when the flash controller signals completion. Erasing or writing inside the read-while-write section of the flash sets a section-busy flag, which blocks reads there. That flag stays set until a re-enable command runs after the operation has finished, or until a page-load starts. A level-sensitive ready interrupt is raised whenever the unit is idle and interrupts are enabled.

Top module: `spm_cmd_arm`

## Requirements
- R1: The arming register bits are bit 0 enable, bit 1 page erase, bit 2 page write, bit 3 lock-bit set and bit 4 section re-enable. Writing one of 00001, 00011, 00101, 01001 or 10001 (bit 4 down to bit 0) arms that command, and `ctrlStatus` shows the value from the cycle after the write.
- R2: Writing any other value leaves `ctrlStatus` unchanged, and a later store strobe produces no `cmdStart`.
- R3: A strobe sampled on any of the four clock edges that follow the arming write executes the command. If no strobe arrives by the fourth edge, the register clears on that edge, and a later strobe has no effect.
- R4: Writing a legal pattern again while armed and idle restarts the four-edge window.
- R5: Executing the load pattern (00001) produces a one-cycle `cmdStart` with `cmdCode` 1 and `cmdAddr` equal to `spmAddr` with bit 0 forced to zero. The register clears on the same edge.
- R6: Executing erase (`cmdCode` 2) or write (`cmdCode` 3) keeps the enable bit and the command bit set until `flashDone` is sampled high, then clears them on that edge. Writes to the arming register are ignored in the meantime.
- R7: An erase or write whose `spmAddr` is below `RWW_LIMIT` sets `rwwBusy` on the execution edge. One at or above `RWW_LIMIT` leaves `rwwBusy` unchanged.
- R8: `rwwBusy` clears when a re-enable command (10001) executes after completion, or when a load executes. The re-enable command issues no `cmdStart`.
- R9: A re-enable command written and strobed while an erase or write is still in progress does not clear `rwwBusy`.
- R10: Executing the lock pattern (01001) produces a one-cycle `cmdStart` with `cmdCode` 4 and clears the register.
- R11: `readyIrq` is high exactly when the enable bit of `ctrlStatus` is 0, `irqEn` is 1 and `globalIrqEn` is 1.
- R12: After reset `ctrlStatus` is 0, `rwwBusy` is 0 and `cmdStart` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlWe | input | 1 | Write strobe for the arming register |
| ctrlWdata | input | 5 | Value written to the arming register |
| irqEn | input | 1 | Ready interrupt enable |
| globalIrqEn | input | 1 | Global interrupt enable |
| spmStrobe | input | 1 | Store-program-memory strobe from the CPU |
| spmAddr | input | ADDR_W | Target byte address of the store |
| flashDone | input | 1 | Completion of erase or write from the flash controller |
| ctrlStatus | output | 5 | Readback of the arming register |
| cmdStart | output | 1 | One-cycle start pulse to the flash controller |
| cmdCode | output | 3 | Command code: 1 load, 2 erase, 3 write, 4 lock |
| cmdAddr | output | ADDR_W | Address passed with the command |
| rwwBusy | output | 1 | Read-while-write section busy, blocks reads of it |
| readyIrq | output | 1 | Level ready interrupt |

## Verification
Several properties are checked on every cycle. The arming register never holds an illegal pattern. While a long operation runs, the enable bit and a long-command bit stay set. An armed register always has a live window count. The start pulse never lasts two cycles. A load address always has bit 0 clear. The busy flag cannot drop while an operation is in flight. Other behaviours need directed scenarios in the bench: the exact edge on which the window expires, the restart of the window, writes being ignored during a long operation, the two different ways the section-busy flag clears, and the gating of the interrupt by its two enables.

// File: rtl/spm_arm_pkg.sv
package spm_arm_pkg;
  localparam int CMD_W   = 5;
  localparam int NUM_CMD = 5;

  localparam int IDX_LOAD  = 0;
  localparam int IDX_ERASE = 1;
  localparam int IDX_WRITE = 2;
  localparam int IDX_LOCK  = 3;
  localparam int IDX_RWWEN = 4;

  typedef enum logic [2:0] {
    CODE_IDLE  = 3'd0,
    CODE_LOAD  = 3'd1,
    CODE_ERASE = 3'd2,
    CODE_WRITE = 3'd3,
    CODE_LOCK  = 3'd4
  } flashCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic doLoad;
    logic doErase;
    logic doWrite;
    logic doLock;
    logic doRwwEn;
    logic opBusy;
  } spmCtl_t;

  // legal pattern for command index: enable bit plus its own bit
  function automatic logic [CMD_W-1:0] cmdPattern(input int idx);
    return CMD_W'(1) | CMD_W'(1 << idx);
  endfunction
endpackage

// File: rtl/spm_arm_ctrl.sv
module spm_arm_ctrl
  import spm_arm_pkg::*;
#(
  parameter int WINDOW = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWe,
  input  logic [CMD_W-1:0] ctrlWdata,
  input  logic             spmStrobe,
  input  logic             flashDone,
  output logic [CMD_W-1:0] armReg,
  output spmCtl_t          ctl
);
  localparam int TMR_W = $clog2(WINDOW + 1);

  logic [TMR_W-1:0]   timer;
  logic               opBusy;
  logic [NUM_CMD-1:0] wrHit;
  logic [NUM_CMD-1:0] armHit;
  logic               wrValid;
  logic               armed;
  logic               exec;
  logic               longCmd;

  for (genvar i = 0; i < NUM_CMD; i++) begin : g_decode
    assign wrHit[i]  = (ctrlWdata == cmdPattern(i));
    assign armHit[i] = (armReg == cmdPattern(i));
  end

  assign wrValid = |wrHit;
  assign armed   = |armReg;
  assign exec    = armed && !opBusy && spmStrobe;
  assign longCmd = armHit[IDX_ERASE] || armHit[IDX_WRITE];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armReg <= '0;
      timer  <= '0;
      opBusy <= 1'b0;
    end else if (opBusy) begin
      if (flashDone) begin
        armReg <= '0;
        opBusy <= 1'b0;
      end
    end else if (exec) begin
      timer <= '0;
      if (longCmd) opBusy <= 1'b1;
      else         armReg <= '0;
    end else if (ctrlWe && wrValid) begin
      armReg <= ctrlWdata;
      timer  <= TMR_W'(WINDOW);
    end else if (armed) begin
      if (timer == TMR_W'(1)) armReg <= '0;
      timer <= timer - TMR_W'(1);
    end
  end

  always_comb begin
    ctl.doLoad  = exec && armHit[IDX_LOAD];
    ctl.doErase = exec && armHit[IDX_ERASE];
    ctl.doWrite = exec && armHit[IDX_WRITE];
    ctl.doLock  = exec && armHit[IDX_LOCK];
    ctl.doRwwEn = exec && armHit[IDX_RWWEN];
    ctl.opBusy  = opBusy;
  end

  // R1
  arm_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armReg != '0) |-> ($countones(armHit) == 1));
  // R6
  busy_holds_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    opBusy |-> (armReg[0] && (armReg[1] || armReg[2])));
  // R3
  window_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    timer <= TMR_W'(WINDOW));
  // R3
  armed_timer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !opBusy) |-> (timer != '0));
  // R1
  exec_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.doLoad, ctl.doErase, ctl.doWrite, ctl.doLock, ctl.doRwwEn}));
endmodule

// File: rtl/spm_arm_dpath.sv
module spm_arm_dpath
  import spm_arm_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int RWW_LIMIT = 16'h7000
) (
  input  logic              clk,
  input  logic              rstN,
  input  spmCtl_t           ctl,
  input  logic [ADDR_W-1:0] spmAddr,
  output logic              cmdStart,
  output flashCode_e        cmdCode,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic              rwwBusy
);
  logic inRww;
  logic issue;
  logic [ADDR_W-1:0] loadAddr;

  assign inRww    = (spmAddr < RWW_LIMIT[ADDR_W-1:0]);
  assign issue    = ctl.doLoad || ctl.doErase || ctl.doWrite || ctl.doLock;
  assign loadAddr = {spmAddr[ADDR_W-1:1], 1'b0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdStart <= 1'b0;
      cmdCode  <= CODE_IDLE;
      cmdAddr  <= '0;
    end else begin
      cmdStart <= issue;
      if (issue) begin
        cmdAddr <= ctl.doLoad ? loadAddr : spmAddr;
        if (ctl.doLoad)       cmdCode <= CODE_LOAD;
        else if (ctl.doErase) cmdCode <= CODE_ERASE;
        else if (ctl.doWrite) cmdCode <= CODE_WRITE;
        else                  cmdCode <= CODE_LOCK;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rwwBusy <= 1'b0;
    else if ((ctl.doErase || ctl.doWrite) && inRww) rwwBusy <= 1'b1;
    else if (ctl.doLoad || ctl.doRwwEn) rwwBusy <= 1'b0;
  end

  // R9
  rww_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.opBusy && rwwBusy) |=> rwwBusy);
  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> !cmdStart);
  // R5
  load_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStart && cmdCode == CODE_LOAD) |-> !cmdAddr[0]);
endmodule

// File: rtl/spm_cmd_arm.sv
module spm_cmd_arm
  import spm_arm_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int WINDOW    = 4,
  parameter int RWW_LIMIT = 16'h7000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [4:0]        ctrlWdata,
  input  logic              irqEn,
  input  logic              globalIrqEn,
  input  logic              spmStrobe,
  input  logic [ADDR_W-1:0] spmAddr,
  input  logic              flashDone,
  output logic [4:0]        ctrlStatus,
  output logic              cmdStart,
  output logic [2:0]        cmdCode,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic              rwwBusy,
  output logic              readyIrq
);
  spmCtl_t          ctl;
  flashCode_e       codeInt;
  logic [CMD_W-1:0] armReg;

  spm_arm_ctrl #(.WINDOW(WINDOW)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .spmStrobe(spmStrobe), .flashDone(flashDone),
    .armReg(armReg), .ctl(ctl)
  );

  spm_arm_dpath #(.ADDR_W(ADDR_W), .RWW_LIMIT(RWW_LIMIT)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .spmAddr(spmAddr),
    .cmdStart(cmdStart), .cmdCode(codeInt), .cmdAddr(cmdAddr),
    .rwwBusy(rwwBusy)
  );

  assign ctrlStatus = armReg;
  assign cmdCode    = codeInt;
  assign readyIrq   = !armReg[0] && irqEn && globalIrqEn;
endmodule

// File: tb/sim_spm_cmd_arm.sv
module sim_spm_cmd_arm;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWe = 1'b0;
  logic [4:0] ctrlWdata = '0;
  logic irqEn = 1'b1;
  logic globalIrqEn = 1'b1;
  logic spmStrobe = 1'b0;
  logic [ADDR_W-1:0] spmAddr = '0;
  logic flashDone = 1'b0;
  logic [4:0] ctrlStatus;
  logic cmdStart;
  logic [2:0] cmdCode;
  logic [ADDR_W-1:0] cmdAddr;
  logic rwwBusy;
  logic readyIrq;

  int total = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;

  spm_cmd_arm u0 (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .irqEn(irqEn), .globalIrqEn(globalIrqEn), .spmStrobe(spmStrobe),
    .spmAddr(spmAddr), .flashDone(flashDone), .ctrlStatus(ctrlStatus),
    .cmdStart(cmdStart), .cmdCode(cmdCode), .cmdAddr(cmdAddr),
    .rwwBusy(rwwBusy), .readyIrq(readyIrq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [4:0] v);
    ctrlWe = 1'b1; ctrlWdata = v; step(); ctrlWe = 1'b0;
  endtask

  task automatic strobe(input logic [ADDR_W-1:0] a);
    spmStrobe = 1'b1; spmAddr = a; step(); spmStrobe = 1'b0;
  endtask

  task automatic done();
    flashDone = 1'b1; step(); flashDone = 1'b0;
  endtask

  task automatic t_reset();
    check("R12 status", ctrlStatus, 0);
    check("R12 rwwBusy", rwwBusy, 0);
    check("R12 cmdStart", cmdStart, 0);
    check("R11 irq idle", readyIrq, 1);
  endtask

  task automatic t_load();
    wr(5'b00001);
    check("R1 load armed", ctrlStatus, 5'b00001);
    check("R11 irq armed", readyIrq, 0);
    strobe(16'h1235);
    check("R5 start", cmdStart, 1);
    check("R5 code", cmdCode, 1);
    check("R5 addr", cmdAddr, 16'h1234);
    check("R5 cleared", ctrlStatus, 0);
    step();
    check("R5 pulse end", cmdStart, 0);
  endtask

  task automatic t_invalid();
    wr(5'b00111);
    check("R2 status", ctrlStatus, 0);
    strobe(16'h0040);
    check("R2 no start", cmdStart, 0);
    wr(5'b00010);
    check("R2 no enable", ctrlStatus, 0);
  endtask

  task automatic t_window();
    wr(5'b00001);
    step(3);
    check("R3 still armed", ctrlStatus, 5'b00001);
    strobe(16'h0010);
    check("R3 edge4 exec", cmdStart, 1);
    step();
    wr(5'b00001);
    step(4);
    check("R3 expired", ctrlStatus, 0);
    strobe(16'h0010);
    check("R3 late strobe", cmdStart, 0);
  endtask

  task automatic t_restart();
    wr(5'b01001);
    step(3);
    wr(5'b01001);
    step(3);
    check("R4 restarted", ctrlStatus, 5'b01001);
    strobe(16'h0020);
    check("R10 lock start", cmdStart, 1);
    check("R10 lock code", cmdCode, 4);
    check("R10 cleared", ctrlStatus, 0);
    step();
    check("R10 pulse end", cmdStart, 0);
  endtask

  task automatic t_erase_rww();
    wr(5'b00011);
    strobe(16'h0100);
    check("R6 erase code", cmdCode, 2);
    check("R6 erase start", cmdStart, 1);
    check("R7 rww set", rwwBusy, 1);
    step(10);
    check("R6 held", ctrlStatus, 5'b00011);
    check("R11 irq busy", readyIrq, 0);
    wr(5'b00001);
    check("R6 write ignored", ctrlStatus, 5'b00011);
    wr(5'b10001);
    strobe(16'h0100);
    check("R9 rww kept", rwwBusy, 1);
    check("R9 status", ctrlStatus, 5'b00011);
    done();
    check("R6 done clears", ctrlStatus, 0);
    check("R8 rww after done", rwwBusy, 1);
    wr(5'b10001);
    check("R1 rwwen armed", ctrlStatus, 5'b10001);
    strobe(16'h0100);
    check("R8 rwwen clears", rwwBusy, 0);
    check("R8 no start", cmdStart, 0);
    check("R8 status", ctrlStatus, 0);
  endtask

  task automatic t_write_outside();
    wr(5'b00101);
    strobe(16'h7800);
    check("R6 write code", cmdCode, 3);
    check("R7 outside", rwwBusy, 0);
    check("R6 write held", ctrlStatus, 5'b00101);
    done();
    check("R6 write done", ctrlStatus, 0);
  endtask

  task automatic t_load_clears();
    wr(5'b00101);
    strobe(16'h0200);
    check("R7 write in rww", rwwBusy, 1);
    done();
    wr(5'b00001);
    strobe(16'h0203);
    check("R8 load clears", rwwBusy, 0);
    check("R5 load addr", cmdAddr, 16'h0202);
  endtask

  task automatic t_irq();
    irqEn = 1'b0; #1;
    check("R11 irqEn off", readyIrq, 0);
    irqEn = 1'b1; globalIrqEn = 1'b0; #1;
    check("R11 global off", readyIrq, 0);
    globalIrqEn = 1'b1; #1;
    check("R11 both on", readyIrq, 1);
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step();
    t_reset();
    t_load();
    t_invalid();
    t_window();
    t_restart();
    t_erase_rww();
    t_write_outside();
    t_load_clears();
    t_irq();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule